// File: doc/BRIEF.md
# Load Return Latency Controller

This block decides, load by load, whether the data read from the data cache goes back to the core one cycle after the access or two. A signed integer load that hits the cache needs an extra cycle for sign extension. When such a load is seen, the controller switches into a sticky delayed mode. In that mode every hit load is returned through a one-deep holding register, so it arrives two cycles after its access.

The controller leaves the mode at the first hit load that is not signed and that can return at the normal latency. That is only allowed when no delayed return is due in the same cycle. A normal-latency return would otherwise meet a held return on the shared bus. Loads that miss the cache take no part in this timing. Their data comes back later on a separate fill path, which the block passes onto the same return bus and marks.

The core drives one access per cycle. It presents the cache read data one cycle after the access. Upstream logic guarantees that a fill never lands in a cycle that already carries a hit return.

Top module: `drm_load_return`

## Requirements
- R1: While reset is low at a clock edge, all registers clear: `dly_mode`, `ret_valid`, `ret_dly_sel` and `ret_from_fill` read 0 in the following cycle, whatever the load inputs are.
- R2: A hit load with `ld_signed`=1 sets `dly_mode` to 1 from the next cycle, and its data is returned two cycles after the access.
- R3: A hit load returned on the delayed path shows `ret_valid`=1 and `ret_dly_sel`=1 two cycles after its access. `ret_data` equals the `cache_rdata` presented in the cycle after the access.
- R4: A hit load with `ld_signed`=0 accessed while `dly_mode`=0 returns one cycle after the access, with `ret_dly_sel`=0 and `ret_data` equal to that cycle's `cache_rdata`.
- R5: A hit load with `ld_signed`=0 accessed while `dly_mode`=1, with no hit load accessed in the cycle before, returns one cycle after the access with `ret_dly_sel`=0. `dly_mode` reads 0 from the next cycle.
- R6: A hit load with `ld_signed`=0 accessed while `dly_mode`=1, directly after a hit load access in the previous cycle, is returned on the delayed path and `dly_mode` stays 1.
- R7: A load with `ld_hit`=0, or a cycle with no load, produces no hit return and leaves `dly_mode` unchanged.
- R8: In a cycle with `fill_valid`=1, `ret_valid`=1, `ret_from_fill`=1, `ret_dly_sel`=0 and `ret_data` equals `fill_data`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | A load accesses the cache this cycle |
| ld_signed | input | 1 | The load is a signed integer load |
| ld_hit | input | 1 | The load hits the data cache |
| cache_rdata | input | DW | Cache read data for the load accessed in the previous cycle |
| fill_valid | input | 1 | Miss data returns this cycle |
| fill_data | input | DW | Miss return data |
| ret_valid | output | 1 | Return bus carries data this cycle |
| ret_data | output | DW | Return bus data |
| ret_dly_sel | output | 1 | Return data comes from the holding register |
| ret_from_fill | output | 1 | Return data comes from the fill path |
| dly_mode | output | 1 | Delayed return mode flag |

## Verification
A normal hit return is due one cycle after its access, a delayed one two cycles after, and a fill in its own cycle. A change of mode shows on `dly_mode` in the cycle after the deciding access. The bench model writes each expected return into a per-cycle slot at the moment it sees the access, at index +1 or +2. It then compares the return bus and the mode flag against that slot in every cycle, shortly after the falling edge, once the inputs for that cycle have settled. Directed runs of signed hits, back-to-back hits, misses and fills are followed by a long random stream.

// File: rtl/drm_pkg.sv
// Package: shared types for the load return latency controller.
// Assumes: nothing beyond IEEE 1800-2017.
package drm_pkg;

    // One in-flight hit load, one cycle after its access.
    typedef struct packed {
        logic vld;   // a hit load was accessed in the previous cycle
        logic dly;   // it takes the delayed (two-cycle) path
    } ret_slot_t;

endpackage

// File: rtl/drm_mode_ctrl.sv
// Module: drm_mode_ctrl
// Decides per hit load whether it returns at normal or delayed latency,
// and holds the sticky delayed-return mode flag.
// Assumes: at most one load access per cycle; pend_dly is high when a
// delayed return is due in the next cycle.
module drm_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_valid,
    input  logic ld_signed,
    input  logic ld_hit,
    input  logic pend_dly,
    output logic acc_ret,
    output logic acc_dly,
    output logic mode
);

    logic mode_q;
    logic sgn_hit;
    logic exit_ok;

    // Classify the access of this cycle.
    always_comb begin
        acc_ret = ld_valid & ld_hit;
        sgn_hit = acc_ret & ld_signed;
        exit_ok = acc_ret & ~ld_signed & mode_q & ~pend_dly;
        acc_dly = sgn_hit | (acc_ret & mode_q & pend_dly);
    end

    // Sticky mode flag: set by a signed hit, cleared by a clean normal return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (sgn_hit)
            mode_q <= 1'b1;
        else if (exit_ok)
            mode_q <= 1'b0;
    end

    assign mode = mode_q;

    a_r2_enter_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hit && ld_signed) |=> mode);

    a_r5_exit_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hit && !ld_signed && mode && !pend_dly) |=> !mode);

    a_r6_stay_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hit && mode && pend_dly) |=> mode);

    a_r7_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && ld_hit) |=> $stable(mode));

endmodule

// File: rtl/drm_ret_pipe.sv
// Module: drm_ret_pipe
// Tracks in-flight hit loads and keeps the one-deep holding register
// for the delayed path.
// Assumes: cache_rdata carries the data for the load accessed one cycle earlier.
module drm_ret_pipe
    import drm_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_ret,
    input  logic          acc_dly,
    input  logic [DW-1:0] cache_rdata,
    output logic          norm_vld,
    output logic          dly_vld,
    output logic [DW-1:0] dly_data,
    output logic          pend_dly
);

    ret_slot_t     s1_q;
    logic          s2_q;
    logic [DW-1:0] hold_q;

    // Stage one: remember the access decision for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_q <= '0;
        else
            s1_q <= '{vld: acc_ret, dly: acc_dly};
    end

    // Stage two: delayed return is due one cycle after stage one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s2_q <= 1'b0;
        else
            s2_q <= s1_q.vld & s1_q.dly;
    end

    // Holding register: capture cache data of a delayed load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (s1_q.vld && s1_q.dly)
            hold_q <= cache_rdata;
    end

    assign norm_vld = s1_q.vld & ~s1_q.dly;
    assign pend_dly = s1_q.vld & s1_q.dly;
    assign dly_vld  = s2_q;
    assign dly_data = hold_q;

    a_r3_delayed_due: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ret && acc_dly) |=> ##1 dly_vld);

    a_r3_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(norm_vld && dly_vld));

endmodule

// File: rtl/drm_ret_mux.sv
// Module: drm_ret_mux
// Selects the source driving the shared return bus.
// Assumes: fill never coincides with a hit return (upstream guarantee).
module drm_ret_mux #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          norm_vld,
    input  logic          dly_vld,
    input  logic [DW-1:0] cache_rdata,
    input  logic [DW-1:0] dly_data,
    input  logic          fill_valid,
    input  logic [DW-1:0] fill_data,
    output logic          ret_valid,
    output logic [DW-1:0] ret_data,
    output logic          ret_dly_sel,
    output logic          ret_from_fill
);

    // Drive the return bus from whichever source is active.
    always_comb begin
        ret_valid     = norm_vld | dly_vld | fill_valid;
        ret_dly_sel   = dly_vld;
        ret_from_fill = fill_valid & ~(norm_vld | dly_vld);
        if (dly_vld)
            ret_data = dly_data;
        else if (norm_vld)
            ret_data = cache_rdata;
        else if (fill_valid)
            ret_data = fill_data;
        else
            ret_data = '0;
    end

    a_r8_fill_alone: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !(norm_vld || dly_vld));

endmodule

// File: rtl/drm_load_return.sv
// Module: drm_load_return (top)
// Load return latency controller: normal returns one cycle after a hit
// access, delayed returns two cycles after, with a sticky delayed mode.
// Assumes: one access per cycle, cache data one cycle after access,
// fills never collide with hit returns.
module drm_load_return #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          ld_signed,
    input  logic          ld_hit,
    input  logic [DW-1:0] cache_rdata,
    input  logic          fill_valid,
    input  logic [DW-1:0] fill_data,
    output logic          ret_valid,
    output logic [DW-1:0] ret_data,
    output logic          ret_dly_sel,
    output logic          ret_from_fill,
    output logic          dly_mode
);

    logic          acc_ret;
    logic          acc_dly;
    logic          pend_dly;
    logic          norm_vld;
    logic          dly_vld;
    logic [DW-1:0] dly_data;

    drm_mode_ctrl i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_signed (ld_signed),
        .ld_hit    (ld_hit),
        .pend_dly  (pend_dly),
        .acc_ret   (acc_ret),
        .acc_dly   (acc_dly),
        .mode      (dly_mode)
    );

    drm_ret_pipe #(.DW(DW)) i_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_ret     (acc_ret),
        .acc_dly     (acc_dly),
        .cache_rdata (cache_rdata),
        .norm_vld    (norm_vld),
        .dly_vld     (dly_vld),
        .dly_data    (dly_data),
        .pend_dly    (pend_dly)
    );

    drm_ret_mux #(.DW(DW)) i_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .norm_vld      (norm_vld),
        .dly_vld       (dly_vld),
        .cache_rdata   (cache_rdata),
        .dly_data      (dly_data),
        .fill_valid    (fill_valid),
        .fill_data     (fill_data),
        .ret_valid     (ret_valid),
        .ret_data      (ret_data),
        .ret_dly_sel   (ret_dly_sel),
        .ret_from_fill (ret_from_fill)
    );

    a_r4_normal_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hit && !ld_signed && !dly_mode) |=> (ret_valid && !ret_dly_sel));

endmodule

// File: tb/test_drm_load_return.sv
`timescale 1ns/1ps
module test_drm_load_return;

    localparam int DW   = 32;
    localparam int CYC  = 20;
    localparam int NSLT = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic          ld_signed = 1'b0;
    logic          ld_hit = 1'b0;
    logic [DW-1:0] cache_rdata = '0;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          ret_valid;
    logic [DW-1:0] ret_data;
    logic          ret_dly_sel;
    logic          ret_from_fill;
    logic          dly_mode;

    always #(CYC/2) clk = ~clk;

    drm_load_return #(.DW(DW)) i_drm_load_return (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_signed(ld_signed),
        .ld_hit(ld_hit), .cache_rdata(cache_rdata), .fill_valid(fill_valid),
        .fill_data(fill_data), .ret_valid(ret_valid), .ret_data(ret_data),
        .ret_dly_sel(ret_dly_sel), .ret_from_fill(ret_from_fill), .dly_mode(dly_mode)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state: per-cycle expected return slots
    bit            e_v   [NSLT];
    bit            e_dly [NSLT];
    bit            e_fil [NSLT];
    logic [DW-1:0] e_d   [NSLT];
    string         e_tag [NSLT];
    bit            m_mode = 0;
    string         m_tag = "R1";
    int            cyc = 0;
    bit            prev_hit = 0;

    function automatic logic [DW-1:0] hit_val(int idx);
        return 32'hA500_0000 ^ (idx * 32'h0000_9E37);
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d %s: actual %h expected %h", tag, cyc, what, act, exp);
        end
    endtask

    // one active cycle: drive, compare, advance the model
    task automatic step(bit v, bit s, bit h, bit f);
        bit exp_fill;
        bit hit, sgn, pend, dly;
        string tg;
        @(negedge clk);
        ld_valid    = v;
        ld_signed   = s;
        ld_hit      = h;
        cache_rdata = prev_hit ? hit_val(cyc - 1) : (32'hDEAD_0000 | cyc);
        exp_fill    = f && !e_v[cyc];
        fill_valid  = exp_fill;
        fill_data   = 32'hF111_0000 ^ cyc;
        if (exp_fill) begin
            e_v[cyc] = 1; e_fil[cyc] = 1; e_dly[cyc] = 0;
            e_d[cyc] = fill_data; e_tag[cyc] = "R8";
        end
        #1;
        tg = e_v[cyc] ? e_tag[cyc] : "R7";
        chk(ret_valid == e_v[cyc], tg, "ret_valid", DW'(ret_valid), DW'(e_v[cyc]));
        if (e_v[cyc]) begin
            chk(ret_dly_sel == e_dly[cyc], tg, "ret_dly_sel", DW'(ret_dly_sel), DW'(e_dly[cyc]));
            chk(ret_from_fill == e_fil[cyc], tg, "ret_from_fill", DW'(ret_from_fill), DW'(e_fil[cyc]));
            chk(ret_data == e_d[cyc], tg, "ret_data", ret_data, e_d[cyc]);
        end
        chk(dly_mode == m_mode, m_tag, "dly_mode", DW'(dly_mode), DW'(m_mode));
        // model the access of this cycle
        hit  = v && h;
        sgn  = hit && s;
        pend = e_v[cyc+1] && e_dly[cyc+1] && !e_fil[cyc+1];
        dly  = sgn || (hit && m_mode && pend);
        if (hit) begin
            if (dly) begin
                e_v[cyc+2] = 1; e_dly[cyc+2] = 1; e_fil[cyc+2] = 0;
                e_d[cyc+2] = hit_val(cyc); e_tag[cyc+2] = sgn ? "R2" : (m_mode ? "R6" : "R3");
            end else begin
                e_v[cyc+1] = 1; e_dly[cyc+1] = 0; e_fil[cyc+1] = 0;
                e_d[cyc+1] = hit_val(cyc); e_tag[cyc+1] = m_mode ? "R5" : "R4";
            end
        end
        if (sgn) begin m_mode = 1; m_tag = "R2"; end
        else if (hit && m_mode && !pend) begin m_mode = 0; m_tag = "R5"; end
        else if (hit && m_mode) m_tag = "R6";
        else m_tag = "R7";
        prev_hit = hit;
        cyc++;
    endtask

    initial begin
        // R1: reset with a signed hit driven, which must be ignored
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ld_valid = 1; ld_signed = 1; ld_hit = 1; fill_valid = 0;
            #1;
            if (i > 0) begin
                chk(!ret_valid, "R1", "ret_valid", DW'(ret_valid), '0);
                chk(!ret_dly_sel, "R1", "ret_dly_sel", DW'(ret_dly_sel), '0);
                chk(!ret_from_fill, "R1", "ret_from_fill", DW'(ret_from_fill), '0);
                chk(!dly_mode, "R1", "dly_mode", DW'(dly_mode), '0);
            end
        end
        @(negedge clk);
        ld_valid = 0; rst_n = 1;
        step(0,0,0,0);
        // R4 normal hit, then idle
        step(1,0,1,0); step(0,0,0,0);
        // R2 enter, idle, R5 exit
        step(1,1,1,0); step(0,0,0,0); step(1,0,1,0); step(0,0,0,0);
        // R6 back-to-back hits stay delayed, then idle and exit
        step(1,1,1,0); step(1,0,1,0); step(1,0,1,0); step(1,0,1,0);
        step(0,0,0,0); step(1,0,1,0); step(0,0,0,0);
        // R7 miss in mode holds it, then miss-followed exit; R8 fills
        step(1,1,1,0); step(1,0,0,1); step(1,1,0,1); step(1,0,1,0);
        step(0,0,0,1); step(0,0,0,1);
        // random stream
        for (int i = 0; i < 3000; i++)
            step(($urandom % 10) < 6, ($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 5) == 0);
        step(0,0,0,0); step(0,0,0,0); step(0,0,0,0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(CYC * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule